// File: doc/BRIEF.md
# Thread-Block Admission and Resource Allocator

This block sits in front of one multiprocessor and decides whether another thread block may become resident there. Each request names how many threads the block has, how many registers each thread uses and how many bytes of shared memory it needs. The allocator checks the request against four pools at once: free residency slots, the resident thread budget, the register pool and the shared-memory pool. If everything fits, it admits the block into a slot and reports the slot number, the first register of the block's region and the number of 32-thread warps the block splits into. If something does not fit, the request waits at the head of the queue with ready low.

Requests are taken strictly in order through a valid/ready handshake, one per cycle at most. A request that can never be admitted, because its thread count is out of range or its demand exceeds a whole pool, is consumed and answered with a reject pulse. A request that could fit later is never skipped. When a resident block finishes, a release naming its slot returns all four resources at once. Registers come from a bump pointer, which returns to zero whenever the multiprocessor becomes empty.

Top module: `tblk_admit`

## Requirements
- R1: After a synchronous reset, no slot is occupied, every pool is fully free, the register pointer is 0, and `adm_valid`, `rej_valid` and `err_flag` are low.
- R2: A request with a thread count of 0 or above 512, or with threads × registers-per-thread above 8192, or with more than 16384 shared-memory bytes, is accepted with `req_ready` high. One cycle later it produces a single `rej_valid` pulse and no admit, and it changes no pool.
- R3: At most 8 blocks are resident. A valid request that arrives while all 8 slots are occupied holds `req_ready` low.
- R4: The resident thread total never exceeds 768. A request that would exceed it holds `req_ready` low.
- R5: A block needs threads × registers-per-thread registers. It is admitted only if that many registers are free in the 8192-entry pool and also if the register pointer plus that demand is at most 8192 (contiguous space). Otherwise `req_ready` is held low.
- R6: The sum of resident shared-memory requests never exceeds 16384 bytes. A request that would exceed it holds `req_ready` low.
- R7: In the cycle after an admitting handshake, `adm_valid` pulses high for one cycle. `adm_slot` then gives the lowest-numbered free slot and `adm_warps` gives ceil(threads/32).
- R8: A release (`rel_valid` with an occupied `rel_slot`) frees that slot's slot, threads, registers and shared memory at the next clock edge. The admission decision in the same cycle still uses the state from before the release.
- R9: `adm_base` equals the register pointer before the admit. The pointer advances by the block's register demand on each admit and becomes 0 at any edge after which no slot is occupied.
- R10: A release naming an unoccupied slot changes nothing and sets `err_flag`, which stays high until reset.
- R11: A stalled request keeps its place. Once releases make room, that same request is admitted with its own parameters before any later request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A block request is offered |
| req_ready | output | 1 | Request is taken this cycle (admitted or rejected) |
| req_threads | input | 10 | Thread count of the block |
| req_rpt | input | 8 | Registers used by each thread |
| req_smem | input | 15 | Shared-memory bytes requested |
| adm_valid | output | 1 | One-cycle admit indication |
| adm_slot | output | 3 | Slot given to the admitted block |
| adm_base | output | 14 | First register of the block's region |
| adm_warps | output | 5 | Warp count of the admitted block |
| rej_valid | output | 1 | One-cycle reject indication |
| rel_valid | input | 1 | A resident block has completed |
| rel_slot | input | 3 | Slot of the completing block |
| err_flag | output | 1 | Sticky flag for a release of an empty slot |

## Verification
On every cycle, the bound checker confirms that the thread, register-pointer and shared-memory counters stay within their pools. It also confirms that the pointer is zero whenever no slot is occupied, that admit and reject never coincide, that every admit follows a handshake with a warp count in range, that impossible thread counts are never stalled, and that the error flag is sticky. Only the bench's scenarios can show the allocation arithmetic itself: which slot and base each admit returns, and the stall and recovery ordering. These cover the thread cap reached by three 256-thread blocks, a register stall caused by fragmentation that clears only once the multiprocessor is empty, the ninth request against the slot limit, and a release in the same cycle as an admit. The bench runs a behavioural model of the pools in parallel and compares every output on every cycle.

// File: rtl/tblk_pkg.sv
package tblk_pkg;
  localparam int DEF_SLOTS      = 8;
  localparam int DEF_SM_THREADS = 768;
  localparam int DEF_BLK_THR    = 512;
  localparam int DEF_REGS       = 8192;
  localparam int DEF_SMEM       = 16384;
  localparam int DEF_WARP       = 32;
  localparam int DEF_THR_W      = 10;
  localparam int DEF_RPT_W      = 8;
  localparam int DEF_SMEM_W     = 15;
endpackage

// File: rtl/tblk_fit.sv
module tblk_fit #(
  parameter int SM_THREADS = 768,
  parameter int BLK_THR    = 512,
  parameter int REGS       = 8192,
  parameter int SMEM       = 16384,
  parameter int WARP       = 32,
  parameter int THR_W      = 10,
  parameter int RPT_W      = 8,
  parameter int SMEM_W     = 15,
  parameter int THRC_W     = 10,
  parameter int REG_W      = 14,
  parameter int SMEM_CW    = 15,
  parameter int WARP_W     = 5
) (
  input  logic [THR_W-1:0]   threads,
  input  logic [RPT_W-1:0]   rpt,
  input  logic [SMEM_W-1:0]  smem,
  input  logic               slot_free,
  input  logic [THRC_W-1:0]  thr_used,
  input  logic [REG_W-1:0]   reg_used,
  input  logic [REG_W-1:0]   reg_ptr,
  input  logic [SMEM_CW-1:0] smem_used,
  output logic               reject,
  output logic               fits,
  output logic [REG_W-1:0]   need,
  output logic [WARP_W-1:0]  warps
);
  logic [31:0] need32;
  logic [31:0] warps32;
  logic        in_range;

  always_comb begin
    need32   = 32'(threads) * 32'(rpt);
    in_range = (threads != '0) && (32'(threads) <= 32'(BLK_THR));
    reject   = !in_range || (need32 > 32'(REGS)) || (32'(smem) > 32'(SMEM));
    fits     = slot_free
             && (32'(thr_used) + 32'(threads) <= 32'(SM_THREADS))
             && (32'(reg_used) + need32 <= 32'(REGS))
             && (32'(reg_ptr) + need32 <= 32'(REGS))
             && (32'(smem_used) + 32'(smem) <= 32'(SMEM));
    need     = REG_W'(need32);
    warps32  = (32'(threads) + 32'(WARP - 1)) / 32'(WARP);
    warps    = WARP_W'(warps32);
  end
endmodule

// File: rtl/tblk_slot_tab.sv
module tblk_slot_tab #(
  parameter int SLOTS   = 8,
  parameter int SLOT_W  = 3,
  parameter int THR_W   = 10,
  parameter int REG_W   = 14,
  parameter int SMEM_W  = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [THR_W-1:0]  wr_thr,
  input  logic [REG_W-1:0]  wr_need,
  input  logic [SMEM_W-1:0] wr_smem,
  input  logic              rel_en,
  input  logic [SLOT_W-1:0] rel_slot,
  output logic [SLOTS-1:0]  occ,
  output logic              free_any,
  output logic [SLOT_W-1:0] free_slot,
  output logic [THR_W-1:0]  rd_thr,
  output logic [REG_W-1:0]  rd_need,
  output logic [SMEM_W-1:0] rd_smem,
  output logic              empty_next
);
  logic [THR_W-1:0]  thr_mem  [SLOTS];
  logic [REG_W-1:0]  need_mem [SLOTS];
  logic [SMEM_W-1:0] smem_mem [SLOTS];
  logic [SLOTS-1:0]  occ_next;

  always_comb begin
    free_any  = 1'b0;
    free_slot = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (!occ[i]) begin
        free_any  = 1'b1;
        free_slot = SLOT_W'(i);
      end
    end
  end

  always_comb begin
    occ_next = occ;
    if (rel_en) occ_next[rel_slot] = 1'b0;
    if (wr_en)  occ_next[free_slot] = 1'b1;
    empty_next = (occ_next == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) occ <= '0;
    else     occ <= occ_next;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      thr_mem[free_slot]  <= wr_thr;
      need_mem[free_slot] <= wr_need;
      smem_mem[free_slot] <= wr_smem;
    end
  end

  assign rd_thr  = thr_mem[rel_slot];
  assign rd_need = need_mem[rel_slot];
  assign rd_smem = smem_mem[rel_slot];
endmodule

// File: rtl/tblk_pool.sv
module tblk_pool #(
  parameter int THR_W   = 10,
  parameter int SMEM_W  = 15,
  parameter int THRC_W  = 10,
  parameter int REG_W   = 14,
  parameter int SMEM_CW = 15
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               add_en,
  input  logic [THR_W-1:0]   add_thr,
  input  logic [REG_W-1:0]   add_need,
  input  logic [SMEM_W-1:0]  add_smem,
  input  logic               sub_en,
  input  logic [THR_W-1:0]   sub_thr,
  input  logic [REG_W-1:0]   sub_need,
  input  logic [SMEM_W-1:0]  sub_smem,
  input  logic               empty_next,
  output logic [THRC_W-1:0]  thr_used,
  output logic [REG_W-1:0]   reg_used,
  output logic [REG_W-1:0]   reg_ptr,
  output logic [SMEM_CW-1:0] smem_used
);
  logic [THRC_W-1:0]  thr_add, thr_sub;
  logic [REG_W-1:0]   reg_add, reg_sub;
  logic [SMEM_CW-1:0] sm_add, sm_sub;

  always_comb begin
    thr_add = add_en ? THRC_W'(add_thr)   : '0;
    thr_sub = sub_en ? THRC_W'(sub_thr)   : '0;
    reg_add = add_en ? add_need           : '0;
    reg_sub = sub_en ? sub_need           : '0;
    sm_add  = add_en ? SMEM_CW'(add_smem) : '0;
    sm_sub  = sub_en ? SMEM_CW'(sub_smem) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_used  <= '0;
      reg_used  <= '0;
      reg_ptr   <= '0;
      smem_used <= '0;
    end else begin
      thr_used  <= thr_used + thr_add - thr_sub;
      reg_used  <= reg_used + reg_add - reg_sub;
      smem_used <= smem_used + sm_add - sm_sub;
      if (empty_next)  reg_ptr <= '0;
      else if (add_en) reg_ptr <= reg_ptr + add_need;
    end
  end
endmodule

// File: rtl/tblk_admit.sv
module tblk_admit
  import tblk_pkg::*;
#(
  parameter int SLOTS      = DEF_SLOTS,
  parameter int SM_THREADS = DEF_SM_THREADS,
  parameter int BLK_THR    = DEF_BLK_THR,
  parameter int REGS       = DEF_REGS,
  parameter int SMEM       = DEF_SMEM,
  parameter int WARP       = DEF_WARP,
  parameter int THR_W      = DEF_THR_W,
  parameter int RPT_W      = DEF_RPT_W,
  parameter int SMEM_W     = DEF_SMEM_W,
  localparam int SLOT_W    = $clog2(SLOTS),
  localparam int REG_W     = $clog2(REGS + 1),
  localparam int THRC_W    = $clog2(SM_THREADS + 1),
  localparam int SMEM_CW   = $clog2(SMEM + 1),
  localparam int WARP_W    = $clog2(BLK_THR / WARP + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [THR_W-1:0]  req_threads,
  input  logic [RPT_W-1:0]  req_rpt,
  input  logic [SMEM_W-1:0] req_smem,
  output logic              adm_valid,
  output logic [SLOT_W-1:0] adm_slot,
  output logic [REG_W-1:0]  adm_base,
  output logic [WARP_W-1:0] adm_warps,
  output logic              rej_valid,
  input  logic              rel_valid,
  input  logic [SLOT_W-1:0] rel_slot,
  output logic              err_flag
);
  logic [SLOTS-1:0]   occ;
  logic               free_any, empty_next;
  logic [SLOT_W-1:0]  free_slot;
  logic [THR_W-1:0]   rd_thr;
  logic [REG_W-1:0]   rd_need;
  logic [SMEM_W-1:0]  rd_smem;
  logic [THRC_W-1:0]  thr_used;
  logic [REG_W-1:0]   reg_used, reg_ptr, need;
  logic [SMEM_CW-1:0] smem_used;
  logic [WARP_W-1:0]  warps;
  logic               reject, fits, hs, do_adm, do_rej, rel_ok, rel_bad;

  tblk_fit #(
    .SM_THREADS(SM_THREADS), .BLK_THR(BLK_THR), .REGS(REGS), .SMEM(SMEM),
    .WARP(WARP), .THR_W(THR_W), .RPT_W(RPT_W), .SMEM_W(SMEM_W),
    .THRC_W(THRC_W), .REG_W(REG_W), .SMEM_CW(SMEM_CW), .WARP_W(WARP_W)
  ) u_fit (
    .threads(req_threads), .rpt(req_rpt), .smem(req_smem),
    .slot_free(free_any), .thr_used(thr_used), .reg_used(reg_used),
    .reg_ptr(reg_ptr), .smem_used(smem_used),
    .reject(reject), .fits(fits), .need(need), .warps(warps)
  );

  assign req_ready = reject || fits;
  assign hs        = req_valid && req_ready;
  assign do_adm    = hs && !reject;
  assign do_rej    = hs && reject;
  assign rel_ok    = rel_valid && occ[rel_slot];
  assign rel_bad   = rel_valid && !occ[rel_slot];

  tblk_slot_tab #(
    .SLOTS(SLOTS), .SLOT_W(SLOT_W), .THR_W(THR_W), .REG_W(REG_W), .SMEM_W(SMEM_W)
  ) u_tab (
    .clk(clk), .rst(rst),
    .wr_en(do_adm), .wr_thr(req_threads), .wr_need(need), .wr_smem(req_smem),
    .rel_en(rel_ok), .rel_slot(rel_slot),
    .occ(occ), .free_any(free_any), .free_slot(free_slot),
    .rd_thr(rd_thr), .rd_need(rd_need), .rd_smem(rd_smem),
    .empty_next(empty_next)
  );

  tblk_pool #(
    .THR_W(THR_W), .SMEM_W(SMEM_W), .THRC_W(THRC_W), .REG_W(REG_W), .SMEM_CW(SMEM_CW)
  ) u_pool (
    .clk(clk), .rst(rst),
    .add_en(do_adm), .add_thr(req_threads), .add_need(need), .add_smem(req_smem),
    .sub_en(rel_ok), .sub_thr(rd_thr), .sub_need(rd_need), .sub_smem(rd_smem),
    .empty_next(empty_next),
    .thr_used(thr_used), .reg_used(reg_used), .reg_ptr(reg_ptr), .smem_used(smem_used)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      adm_valid <= 1'b0;
      adm_slot  <= '0;
      adm_base  <= '0;
      adm_warps <= '0;
      rej_valid <= 1'b0;
      err_flag  <= 1'b0;
    end else begin
      adm_valid <= do_adm;
      rej_valid <= do_rej;
      if (do_adm) begin
        adm_slot  <= free_slot;
        adm_base  <= reg_ptr;
        adm_warps <= warps;
      end
      if (rel_bad) err_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/tblk_admit_chk.sv
module tblk_admit_chk #(
  parameter int SLOTS      = 8,
  parameter int SM_THREADS = 768,
  parameter int BLK_THR    = 512,
  parameter int REGS       = 8192,
  parameter int SMEM       = 16384,
  parameter int WARP       = 32,
  parameter int THR_W      = 10,
  parameter int THRC_W     = 10,
  parameter int REG_W      = 14,
  parameter int SMEM_CW    = 15,
  parameter int WARP_W     = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_ready,
  input logic [THR_W-1:0]   req_threads,
  input logic               adm_valid,
  input logic [WARP_W-1:0]  adm_warps,
  input logic               rej_valid,
  input logic               err_flag,
  input logic [THRC_W-1:0]  thr_used,
  input logic [REG_W-1:0]   reg_ptr,
  input logic [SMEM_CW-1:0] smem_used,
  input logic [SLOTS-1:0]   occ
);
  AST_REJ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(adm_valid && rej_valid)); // R2
  AST_ZERO_THR_TAKEN: assert property (@(posedge clk) disable iff (rst) (req_valid && req_threads == '0) |-> req_ready); // R2
  AST_THR_CAP: assert property (@(posedge clk) disable iff (rst) 32'(thr_used) <= 32'(SM_THREADS)); // R4
  AST_REG_PTR_CAP: assert property (@(posedge clk) disable iff (rst) 32'(reg_ptr) <= 32'(REGS)); // R5
  AST_SMEM_CAP: assert property (@(posedge clk) disable iff (rst) 32'(smem_used) <= 32'(SMEM)); // R6
  AST_ADM_AFTER_HS: assert property (@(posedge clk) disable iff (rst) adm_valid |-> $past(req_valid && req_ready)); // R7
  AST_WARP_RANGE: assert property (@(posedge clk) disable iff (rst) adm_valid |-> (adm_warps != '0 && 32'(adm_warps) <= 32'(BLK_THR / WARP))); // R7
  AST_EMPTY_PTR_ZERO: assert property (@(posedge clk) disable iff (rst) (occ == '0) |-> (reg_ptr == '0)); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst) err_flag |=> err_flag); // R10
endmodule

bind tblk_admit tblk_admit_chk #(
  .SLOTS(SLOTS), .SM_THREADS(SM_THREADS), .BLK_THR(BLK_THR), .REGS(REGS), .SMEM(SMEM),
  .WARP(WARP), .THR_W(THR_W), .THRC_W(THRC_W), .REG_W(REG_W), .SMEM_CW(SMEM_CW),
  .WARP_W(WARP_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_threads(req_threads), .adm_valid(adm_valid), .adm_warps(adm_warps),
  .rej_valid(rej_valid), .err_flag(err_flag), .thr_used(thr_used),
  .reg_ptr(reg_ptr), .smem_used(smem_used), .occ(occ)
);

// File: tb/sim_tblk_admit.sv
module sim_tblk_admit;
  localparam int CLK_PERIOD = 10;
  localparam int NSLOT = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [9:0]  req_threads = '0;
  logic [7:0]  req_rpt = '0;
  logic [14:0] req_smem = '0;
  logic        adm_valid;
  logic [2:0]  adm_slot;
  logic [13:0] adm_base;
  logic [4:0]  adm_warps;
  logic        rej_valid;
  logic        rel_valid = 1'b0;
  logic [2:0]  rel_slot = '0;
  logic        err_flag;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tblk_admit u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_threads(req_threads), .req_rpt(req_rpt), .req_smem(req_smem),
    .adm_valid(adm_valid), .adm_slot(adm_slot), .adm_base(adm_base),
    .adm_warps(adm_warps), .rej_valid(rej_valid),
    .rel_valid(rel_valid), .rel_slot(rel_slot), .err_flag(err_flag)
  );

  // behavioural model state
  bit m_occ [NSLOT];
  int m_thr_s [NSLOT];
  int m_reg_s [NSLOT];
  int m_sm_s [NSLOT];
  int m_thr, m_reg, m_ptr, m_sm;
  bit e_adm, e_rej, e_err;
  int e_slot, e_base, e_warps;

  function automatic void m_eval(output bit rej, output bit fit, output int need, output int fs);
    int t;
    t = int'(req_threads);
    need = t * int'(req_rpt);
    rej = (t < 1) || (t > 512) || (need > 8192) || (int'(req_smem) > 16384);
    fs = -1;
    for (int i = 0; i < NSLOT; i++) if (!m_occ[i] && fs < 0) fs = i;
    fit = (fs >= 0) && (m_thr + t <= 768) && (m_reg + need <= 8192)
          && (m_ptr + need <= 8192) && (m_sm + int'(req_smem) <= 16384);
  endfunction

  function automatic bit m_ready();
    bit rej, fit;
    int need, fs;
    m_eval(rej, fit, need, fs);
    return rej || fit;
  endfunction

  always @(posedge clk) begin
    bit rej, fit, any;
    int need, fs, rs;
    if (rst) begin
      for (int i = 0; i < NSLOT; i++) m_occ[i] = 1'b0;
      m_thr = 0; m_reg = 0; m_ptr = 0; m_sm = 0;
      e_adm = 0; e_rej = 0; e_err = 0; e_slot = 0; e_base = 0; e_warps = 0;
    end else begin
      m_eval(rej, fit, need, fs);
      rs = int'(rel_slot);
      e_adm = 0; e_rej = 0;
      if (req_valid && rej) e_rej = 1;
      if (req_valid && !rej && fit) begin
        e_adm = 1; e_slot = fs; e_base = m_ptr;
        e_warps = (int'(req_threads) + 31) / 32;
      end
      if (rel_valid && !m_occ[rs]) e_err = 1;
      if (rel_valid && m_occ[rs]) begin
        m_occ[rs] = 0;
        m_thr -= m_thr_s[rs]; m_reg -= m_reg_s[rs]; m_sm -= m_sm_s[rs];
      end
      if (e_adm) begin
        m_occ[fs] = 1;
        m_thr_s[fs] = int'(req_threads); m_reg_s[fs] = need; m_sm_s[fs] = int'(req_smem);
        m_thr += int'(req_threads); m_reg += need; m_sm += int'(req_smem);
        m_ptr += need;
      end
      any = 0;
      for (int i = 0; i < NSLOT; i++) if (m_occ[i]) any = 1;
      if (!any) m_ptr = 0;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R3 R4 R5 R6 R11 req_ready", int'(req_ready), int'(m_ready()));
      chk("R7 R8 adm_valid", int'(adm_valid), int'(e_adm));
      if (e_adm) begin
        chk("R7 adm_slot", int'(adm_slot), e_slot);
        chk("R5 R9 adm_base", int'(adm_base), e_base);
        chk("R7 adm_warps", int'(adm_warps), e_warps);
      end
      chk("R2 rej_valid", int'(rej_valid), int'(e_rej));
      chk("R10 err_flag", int'(err_flag), int'(e_err));
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic offer(int t, int r, int s);
    req_valid = 1'b1; req_threads = 10'(t); req_rpt = 8'(r); req_smem = 15'(s);
  endtask

  task automatic wait_hs();
    bit got;
    got = 1'b0;
    while (!got) begin
      @(negedge clk); got = req_ready;
      @(posedge clk); #1;
    end
    req_valid = 1'b0;
  endtask

  task automatic send(int t, int r, int s);
    offer(t, r, s); wait_hs();
  endtask

  task automatic rel(int s);
    rel_valid = 1'b1; rel_slot = 3'(s); tick(); rel_valid = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    done = 1'b1;
    n_bad++;
    $display("FAIL R11 watchdog actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    // R1: reset state at the ports
    @(negedge clk);
    chk("R1 adm_valid after reset", int'(adm_valid), 0);
    chk("R1 err_flag after reset", int'(err_flag), 0);
    tick();
    // R4: three 256-thread blocks fill the thread budget
    send(256, 10, 4096); send(256, 10, 4096); send(256, 10, 4096);
    offer(33, 1, 0); repeat (3) tick();        // R4 stall, R11 head held
    rel(1); wait_hs();                          // R8 R11 admit into slot 1
    rel(0); rel(2); rel(1); tick();             // R9 pointer back to zero
    // R5: fragmentation stall, cleared only by emptying
    send(256, 11, 0); send(256, 11, 0);
    offer(256, 11, 0); repeat (2) tick();
    rel(0); repeat (2) tick();
    rel(1); wait_hs();
    rel(0); tick();
    // R2: rejects
    send(0, 1, 0); send(513, 1, 0); send(512, 17, 0); send(1, 0, 16385);
    // R7: warp rounding
    send(31, 0, 0); send(32, 0, 0); send(33, 0, 0); send(512, 0, 0);
    for (int i = 0; i < 4; i++) rel(i);
    tick();
    // R6: shared memory
    send(32, 0, 8192); send(32, 0, 8192);
    offer(32, 0, 1); repeat (2) tick();
    rel(0); wait_hs();
    rel(0); rel(1); tick();
    // R3: slot limit, ninth request stalls
    for (int i = 0; i < 8; i++) send(32, 0, 0);
    offer(32, 0, 0); repeat (2) tick();
    rel(3); wait_hs();
    // R8: release and admit in the same cycle
    rel(5);
    offer(64, 4, 100); rel_valid = 1'b1; rel_slot = 3'd2;
    wait_hs(); rel_valid = 1'b0;
    for (int i = 0; i < 8; i++) rel(i);
    tick();
    // R10: release of an empty slot, flag stays set
    rel(6); repeat (3) tick();
    send(16, 2, 0);
    repeat (2) tick();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule